// File: doc/BRIEF.md
# Chunk-Bounded Instruction Decode Grouper

This block sits in a fixed-width instruction front end. It picks which instructions are decoded together in each cycle. Upstream logic presents a window of up to `W` pending instruction records, oldest in lane 0. Each record carries a start address, a byte length and a flag marking a taken loop-closing branch. In the same cycle the block reports how many of those records it consumes. The producer drops the consumed records and shifts the remaining ones down for the next cycle. The consumed records form the decode group, which is registered onto the output as a count and a slot-valid mask.

Two limits bound a group: the decode width `W` and the aligned 16-byte fetch chunk. An instruction is placed in the chunk that holds its last byte, so an instruction that crosses a boundary goes with the later chunk. The chunk of the oldest pending instruction sets the chunk for the cycle. A taken branch is always the last instruction of its group. The branch target, which is the loop top, therefore starts the next group, and its chunk is taken from its own address. The number of cycles a loop needs follows from where its bytes fall, not just from how many instructions it holds.

A cycles-per-iteration counter reports the number of cycles between successive taken branches. This lets a loop's steady-state cost be compared against a model.

Top module: `decode_grouper`

## Requirements
- R1: While reset is low, and on the first cycle after it, `grp_cnt`, `grp_mask`, `iter_cyc` and `iter_done` are all zero.
- R2: `grp_cnt` never exceeds `W`. `grp_mask` has exactly its low `grp_cnt` bits set, with slot 0 as bit 0.
- R3: Every instruction taken in one cycle has the same chunk index, computed as (addr + len - 1) >> 4. An instruction that crosses a 16-byte boundary therefore groups with the later chunk.
- R4: Whenever lane 0 is valid, at least one record is consumed.
- R5: A record flagged as a taken branch is the last one consumed in its cycle. The lanes after it wait, even when they are valid and in the same chunk.
- R6: `grp_cnt` and `grp_mask` show the group consumed on the previous cycle.
- R7: `iter_done` pulses one cycle after a group containing a taken branch. In that cycle `iter_cyc` holds the number of cycles since the previous such group, counting both the first and the last cycle.
- R8: With `W` = 5, 15 one-byte instructions in one chunk decode in 3 cycles, and 16 decode as 5-5-5-1.
- R9: When a loop's first instruction starts 2 bytes before a 32-byte boundary, the loop costs one cycle more than the same loop aligned. This holds for sizes 8 and 19, with a 2-byte first instruction, 1-byte middles and a 2-byte closing branch.
- R10: With `W` = 4 and that same instruction shape on a 32-byte-aligned start, a 35-instruction loop takes 9 cycles and a 36-instruction loop takes 10.
- R11: For every loop size from 3 to 100, at both alignments, the steady-state `iter_cyc` equals the count given by the chunk and width rules alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | W | Per-lane record valid; lanes are oldest-first and contiguous |
| in_addr | input | W x AW | Per-lane start byte address |
| in_len | input | W x 4 | Per-lane length in bytes (1 to 15) |
| in_brt | input | W | Per-lane taken loop-closing branch flag |
| in_take | output | CW | Records consumed this cycle (combinational) |
| grp_cnt | output | CW | Instructions in the group decoded last cycle |
| grp_mask | output | W | Slot-valid bits of that group |
| iter_cyc | output | IW | Cycles taken by the last completed loop iteration |
| iter_done | output | 1 | One-cycle pulse when `iter_cyc` is updated |

## Verification
A wrong chunk comparison or a wrong width limit first appears combinationally on `in_take`, in the same cycle, and on `grp_cnt` one cycle later. Its lasting effect is a loop whose `iter_cyc` is off by one or more cycles from the second iteration onward. A group that runs past a taken branch shows up immediately as a wrong `grp_cnt` on small loops, and within one iteration as a shorter cycle count. Because of this, the steady-state cycle count is compared with an independent model for every size from 3 to 100 at both alignments, and with hand-computed values for the alignment and width examples.

// File: rtl/dgrp_pkg.sv
// Shared constants for the decode grouper.
// Assumes byte addressing and a fetch chunk whose size is a power of two.
package dgrp_pkg;
    localparam int CHUNK_LG = 4;   // log2 of the fetch chunk size in bytes
    localparam int LEN_W    = 4;   // width of an instruction length field
endpackage

// File: rtl/dgrp_lane_chunk.sv
// Computes the chunk index that owns one instruction record: the chunk
// holding its last byte. A record that crosses a chunk boundary therefore
// belongs to the later chunk.
// Assumes len is 1 or more; a zero length is not produced upstream.
module dgrp_lane_chunk #(
    parameter int AW = 16,
    localparam int KW = AW - dgrp_pkg::CHUNK_LG
) (
    input  logic [AW-1:0]              addr,
    input  logic [dgrp_pkg::LEN_W-1:0] len,
    output logic [KW-1:0]              chunk
);
    logic [AW-1:0] last_byte;

    // last byte address of the record, then its chunk index
    always_comb begin
        last_byte = addr + AW'(len) - AW'(1);
        chunk     = last_byte[AW-1:dgrp_pkg::CHUNK_LG];
    end
endmodule

// File: rtl/dgrp_group_select.sv
// Chooses how many oldest pending records join this cycle's decode group.
// A lane joins when all older lanes joined, it is valid, it shares lane 0's
// chunk, and no older lane is a taken branch. Lane 0 joins whenever valid.
// Assumes valid lanes form a contiguous run starting at lane 0.
module dgrp_group_select #(
    parameter int W  = 4,
    parameter int KW = 12,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]         vld,
    input  logic [W-1:0][KW-1:0] chunk,
    input  logic [W-1:0]         brt,
    output logic [CW-1:0]        take,
    output logic [W-1:0]         mask,
    output logic                 ends_loop
);
    // join chain across lanes, then population count
    always_comb begin
        mask    = '0;
        mask[0] = vld[0];
        for (int i = 1; i < W; i++) begin
            mask[i] = mask[i-1] & vld[i] & (chunk[i] == chunk[0]) & ~brt[i-1];
        end
        take = '0;
        for (int i = 0; i < W; i++) begin
            take = take + CW'(mask[i]);
        end
        ends_loop = |(mask & brt);
    end
endmodule

// File: rtl/dgrp_iter_counter.sv
// Counts cycles between groups that close a loop. It reports the count,
// first and last cycle included, with a one-cycle done pulse.
// Assumes IW is wide enough for the longest loop; the counter saturates.
module dgrp_iter_counter #(
    parameter int IW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap,
    output logic [IW-1:0] iter_cyc,
    output logic          iter_done
);
    logic [IW-1:0] run_q;

    // running cycle count, latched and cleared when a loop closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= '0;
            iter_cyc  <= '0;
            iter_done <= 1'b0;
        end else begin
            iter_done <= wrap;
            if (wrap) begin
                iter_cyc <= run_q + IW'(1);
                run_q    <= '0;
            end else if (run_q != {IW{1'b1}}) begin
                run_q <= run_q + IW'(1);
            end
        end
    end
endmodule

// File: rtl/decode_grouper.sv
// Top of the decode grouper. Each cycle it consumes up to W oldest records
// that lie in one 16-byte chunk and do not follow a taken branch. It then
// registers the group as a count and a slot mask, and times loop iterations.
// Assumes the producer shifts unconsumed records down to lane 0 each cycle.
module decode_grouper #(
    parameter int W  = 4,
    parameter int AW = 16,
    parameter int IW = 12,
    localparam int CW = $clog2(W + 1),
    localparam int KW = AW - dgrp_pkg::CHUNK_LG
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [W-1:0]                      in_vld,
    input  logic [W-1:0][AW-1:0]              in_addr,
    input  logic [W-1:0][dgrp_pkg::LEN_W-1:0] in_len,
    input  logic [W-1:0]                      in_brt,
    output logic [CW-1:0]                     in_take,
    output logic [CW-1:0]                     grp_cnt,
    output logic [W-1:0]                      grp_mask,
    output logic [IW-1:0]                     iter_cyc,
    output logic                              iter_done
);
    logic [W-1:0][KW-1:0] lane_chunk;
    logic [W-1:0]         sel_mask;
    logic                 sel_ends;

    for (genvar g = 0; g < W; g++) begin : g_lane
        dgrp_lane_chunk #(.AW(AW)) u_chunk (
            .addr  (in_addr[g]),
            .len   (in_len[g]),
            .chunk (lane_chunk[g])
        );
    end

    dgrp_group_select #(.W(W), .KW(KW)) u_sel (
        .vld       (in_vld),
        .chunk     (lane_chunk),
        .brt       (in_brt),
        .take      (in_take),
        .mask      (sel_mask),
        .ends_loop (sel_ends)
    );

    // register the group decoded this cycle onto the outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_cnt  <= '0;
            grp_mask <= '0;
        end else begin
            grp_cnt  <= in_take;
            grp_mask <= sel_mask;
        end
    end

    dgrp_iter_counter #(.IW(IW)) u_iter (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap      (sel_ends),
        .iter_cyc  (iter_cyc),
        .iter_done (iter_done)
    );
endmodule

// File: rtl/decode_grouper_chk.sv
// Property checker for decode_grouper, bound to every instance.
// Assumes the same parameters as the instance it watches.
module decode_grouper_chk #(
    parameter int W  = 4,
    parameter int AW = 16,
    parameter int IW = 12,
    localparam int CW = $clog2(W + 1)
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [W-1:0]                      in_vld,
    input logic [W-1:0][AW-1:0]              in_addr,
    input logic [W-1:0][dgrp_pkg::LEN_W-1:0] in_len,
    input logic [W-1:0]                      in_brt,
    input logic [CW-1:0]                     in_take,
    input logic [CW-1:0]                     grp_cnt,
    input logic [W-1:0]                      grp_mask,
    input logic [IW-1:0]                     iter_cyc,
    input logic                              iter_done
);
    logic          chunk_bad;
    logic          branch_bad;
    logic [W-1:0]  mask_exp;
    logic [W:0]    one_sh;
    logic [AW-1:0] end0;
    logic [AW-1:0] endi;

    // independent view of the consumed lanes: chunk match, branch position
    always_comb begin
        chunk_bad  = 1'b0;
        branch_bad = 1'b0;
        end0 = in_addr[0] + AW'(in_len[0]) - AW'(1);
        for (int i = 0; i < W; i++) begin
            endi = in_addr[i] + AW'(in_len[i]) - AW'(1);
            if (CW'(i) < in_take) begin
                if (!in_vld[i] || ((endi >> dgrp_pkg::CHUNK_LG) != (end0 >> dgrp_pkg::CHUNK_LG)))
                    chunk_bad = 1'b1;
                if (in_brt[i] && (CW'(i + 1) < in_take))
                    branch_bad = 1'b1;
            end
        end
        one_sh   = (W + 1)'(1) << grp_cnt;
        mask_exp = W'(one_sh - (W + 1)'(1));
    end

    // R2
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_cnt <= CW'(W)) && (grp_mask == mask_exp));

    // R3
    chunk_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chunk_bad);

    // R4
    progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld[0] |-> (in_take != '0));

    // R5
    branch_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !branch_bad);

    // R6
    grp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (grp_cnt == $past(in_take)));

    // R7
    iter_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iter_done |-> (iter_cyc != '0));
endmodule

bind decode_grouper decode_grouper_chk #(.W(W), .AW(AW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_addr   (in_addr),
    .in_len    (in_len),
    .in_brt    (in_brt),
    .in_take   (in_take),
    .grp_cnt   (grp_cnt),
    .grp_mask  (grp_mask),
    .iter_cyc  (iter_cyc),
    .iter_done (iter_done)
);

// File: tb/decode_grouper_test.sv
// Loop feeder: presents an endless loop body to one grouper instance,
// shifting by the consumed count each cycle. Body shape: first instruction
// flen bytes, middle ones 1 byte, last one llen bytes and a taken branch.
module dgrp_feeder #(
    parameter int W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  int          n,
    input  int          base,
    input  int          flen,
    input  int          llen,
    output int          g_cnt,
    output int          g_mask,
    output int          icyc,
    output logic        idone
);
    localparam int CW = $clog2(W + 1);
    logic [W-1:0]           vld;
    logic [W-1:0][15:0]     addr;
    logic [W-1:0][3:0]      len;
    logic [W-1:0]           brt;
    logic [CW-1:0]          take;
    logic [CW-1:0]          cnt;
    logic [W-1:0]           msk;
    logic [11:0]            cyc;
    int ptr = 0;

    decode_grouper #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_vld(vld), .in_addr(addr),
        .in_len(len), .in_brt(brt), .in_take(take),
        .grp_cnt(cnt), .grp_mask(msk), .iter_cyc(cyc), .iter_done(idone)
    );

    always_comb begin
        g_cnt  = int'(cnt);
        g_mask = int'(msk);
        icyc   = int'(cyc);
    end

    initial begin
        vld = '0; addr = '0; len = '0; brt = '0;
    end

    always @(negedge clk) begin
        if (!rst_n) ptr = 0;
        else        ptr = (ptr + int'(take)) % n;
        for (int i = 0; i < W; i++) begin
            int idx;
            idx = (ptr + i) % n;
            vld[i]  = 1'b1;
            addr[i] = 16'(base + ((idx == 0) ? 0 : flen + idx - 1));
            len[i]  = 4'((idx == 0) ? flen : ((idx == n - 1) ? llen : 1));
            brt[i]  = (idx == n - 1);
        end
    end
endmodule

module decode_grouper_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int n = 8, base = 0, flen = 2, llen = 2;
    int checks = 0, errors = 0;
    int c4, m4, y4, c5, m5, y5;
    logic d4, d5;

    always #2 clk = ~clk;

    dgrp_feeder #(.W(4)) f4 (.clk(clk), .rst_n(rst_n), .n(n), .base(base),
        .flen(flen), .llen(llen), .g_cnt(c4), .g_mask(m4), .icyc(y4), .idone(d4));
    dgrp_feeder #(.W(5)) f5 (.clk(clk), .rst_n(rst_n), .n(n), .base(base),
        .flen(flen), .llen(llen), .g_cnt(c5), .g_mask(m5), .icyc(y5), .idone(d5));

    // columns: width, size, start address, first len, last len, cycles
    localparam int NV = 12;
    localparam int VEC [NV][6] = '{
        '{4, 35,  0, 2, 2,  9},   // R10
        '{4, 36,  0, 2, 2, 10},   // R10
        '{4, 31,  0, 2, 2,  9},   // R3 closing branch straddles into next chunk
        '{4, 19,  0, 2, 2,  5},   // R9 aligned reference
        '{4, 19, 30, 2, 2,  6},   // R9
        '{4,  8,  0, 2, 2,  2},   // R9 aligned reference
        '{4,  8, 30, 2, 2,  3},   // R9
        '{4,  3,  0, 2, 2,  1},   // R5
        '{5, 15,  0, 1, 1,  3},   // R8
        '{5, 16,  0, 1, 1,  4},   // R8
        '{4, 15,  0, 1, 1,  4},   // R8 width-4 contrast
        '{5, 35,  0, 2, 2,  8}    // R8
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // cycles per iteration from the width and chunk rules alone
    function automatic int model(int w, int sz, int b, int fl, int ll);
        int cyc = 0, fill = 0, cur = -1;
        for (int i = 0; i < sz; i++) begin
            int a, l, ec;
            a  = b + ((i == 0) ? 0 : fl + i - 1);
            l  = (i == 0) ? fl : ((i == sz - 1) ? ll : 1);
            ec = (a + l - 1) / 16;
            if (fill == 0 || fill == w || ec != cur) begin
                cyc++;
                fill = 0;
                cur  = ec;
            end
            fill++;
        end
        return cyc;
    endfunction

    // reset, then run until the third iteration completes; return its cost
    task automatic run_loop(input int w, input int sz, input int b,
                            input int fl, input int ll, output int cyc);
        int seen = 0, guard = 0;
        cyc = -1;
        @(negedge clk);
        rst_n = 1'b0; n = sz; base = b; flen = fl; llen = ll;
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
        while (seen < 3 && guard < 3000) begin
            @(negedge clk);
            guard++;
            if (w == 4 && d4) begin seen++; cyc = y4; end
            if (w == 5 && d5) begin seen++; cyc = y5; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        // R1: held in reset, then first cycle after release
        repeat (3) @(negedge clk);
        check("R1 cnt", c4, 0);
        check("R1 mask", m4, 0);
        check("R1 iter", y4 + int'(d4), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 iter after release", int'(d4), 0);
        // R6 R2: aligned 8-instruction body, first group is 4 wide
        check("R6 first group cnt", c4, 4);
        check("R2 first group mask", m4, 15);

        foreach (VEC[v]) begin
            run_loop(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], cyc);
            check($sformatf("R7 vector %0d", v), cyc, VEC[v][5]);
        end

        // R5: 3-instruction loop, valid lanes after the branch must wait
        run_loop(4, 3, 0, 2, 2, cyc);
        @(negedge clk);
        check("R5 cnt", c4, 3);
        check("R5 mask", m4, 7);

        // R8: full 5-wide group
        run_loop(5, 15, 0, 1, 1, cyc);
        @(negedge clk);
        check("R8 cnt", c5, 5);
        check("R8 mask", m5, 31);

        // R11: sweep sizes and alignments against the model
        for (int sz = 3; sz <= 100; sz++) begin
            run_loop(4, sz, 0, 2, 2, cyc);
            check($sformatf("R11 w4 aligned n=%0d", sz), cyc, model(4, sz, 0, 2, 2));
            run_loop(4, sz, 30, 2, 2, cyc);
            check($sformatf("R11 w4 off30 n=%0d", sz), cyc, model(4, sz, 30, 2, 2));
            run_loop(5, sz, 0, 2, 2, cyc);
            check($sformatf("R11 w5 aligned n=%0d", sz), cyc, model(5, sz, 0, 2, 2));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule